// File: doc/BRIEF.md
# Split/Cascade Timer-Counter with Capture

This block is a 16-bit count engine built from two 8-bit halves. A two-bit mode decides how the halves work. They can run as two separate timers, or as a timer beside an event counter. They can also be chained into one 16-bit timer or one 16-bit event counter. In timer use, a half advances on the one-cycle tick of a programmable prescaler, which divides the system clock by its setting plus one. In event use, a half advances on each rising edge of a synchronized external event input.

Each half has a match register. When the count equals the match value on an advance, the count returns to zero and a sticky interrupt flag is raised. Software clears the flag by writing a one to it. Two separately synchronized trigger inputs copy the live count into capture registers. In the chained modes, the low trigger captures the full 16 bits. Writing the mode register restarts both counters and both prescalers.

Writes use a simple address/data port with six registers:
- 0: mode, bits 1:0
- 1: low prescaler
- 2: high prescaler
- 3: low match
- 4: high match
- 5: flag clear

Top module: `mtc_timer`

## Requirements
- R1: During and after reset, the count, both capture outputs and both flags read zero. The mode comes up as 3 (chained event count), and both match registers hold all ones, so with no events nothing moves.
- R2: In mode 0, each half advances once per (P+1) clocks, where P is its own prescaler (register 1 for low, register 2 for high). The first advance falls P+1 clock edges after the mode write.
- R3: In mode 1, the low half is a prescaled timer using register 1. The high half (count bits 15:8) adds one for every rising edge on the event input.
- R4: In mode 2, the halves form one 16-bit timer driven by the low prescaler, and carries pass from bit 7 into bit 8.
- R5: In mode 3, the 16-bit count changes only on a rising event edge and adds one per edge.
- R6: On an advance, a half whose count equals its match value returns to zero and raises its flag. The low half uses register 3 and irq_lo; the high half uses register 4 and irq_hi. In modes 2 and 3, the 16-bit match value is {register 4, register 3}, and a wrap raises irq_lo only.
- R7: A flag stays set until register 5 is written with a one in its bit: bit 0 clears irq_lo and bit 1 clears irq_hi. A zero bit leaves its flag untouched.
- R8: In modes 0 and 1, a rising edge on cap_lo_in copies the low count to cap_lo_o, and a rising edge on cap_hi_in copies the high count to cap_hi_o. The copied value is the count held two clocks after the input edge is first sampled.
- R9: In modes 2 and 3, a rising edge on cap_lo_in copies the full 16-bit count into {cap_hi_o, cap_lo_o}. In these modes, cap_hi_in has no effect.
- R10: Any write to register 0 sets the count to zero on that edge, and the prescalers restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| evt_in | input | 1 | External event input, asynchronous |
| cap_lo_in | input | 1 | Low/16-bit capture trigger, asynchronous |
| cap_hi_in | input | 1 | High capture trigger, asynchronous |
| count_o | output | 16 | Live count, high half in bits 15:8 |
| cap_lo_o | output | 8 | Low capture register |
| cap_hi_o | output | 8 | High capture register |
| irq_lo | output | 1 | Low/16-bit match flag |
| irq_hi | output | 1 | High match flag |

## Verification
A mode write takes effect on its own clock edge. After it, the count at edge k equals the number of prescaler ticks so far, taken modulo the match value plus one. The bench waits exactly k edges and samples at the following falling edge. A trigger or event edge passes through three flops, so the bench waits several clocks after each pulse before sampling, and it computes captured values from the fixed three-edge delay. Flag checks are made with the block parked in mode 3 with no events, so nothing can change a flag between the stimulus and the sample.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    typedef enum logic [1:0] {
        MODE_SPLIT_TMR = 2'd0,
        MODE_TMR_EVT   = 2'd1,
        MODE_CAS_TMR   = 2'd2,
        MODE_CAS_EVT   = 2'd3
    } mtc_mode_e;

    localparam int         ADDR_W    = 3;
    localparam logic [2:0] A_MODE    = 3'd0;
    localparam logic [2:0] A_PRE_LO  = 3'd1;
    localparam logic [2:0] A_PRE_HI  = 3'd2;
    localparam logic [2:0] A_MAT_LO  = 3'd3;
    localparam logic [2:0] A_MAT_HI  = 3'd4;
    localparam logic [2:0] A_FLAGCLR = 3'd5;
endpackage

// File: rtl/mtc_edge_sync.sv
module mtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int SW = STAGES + 1;
    logic [SW-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SW-2:0], din};
    end

    assign rise = sh[SW-2] & ~sh[SW-1];

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] pcnt;

    assign tick = (pcnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           pcnt <= '0;
        else if (clr || tick) pcnt <= '0;
        else                  pcnt <= pcnt + 1'b1;
    end

    // R2
    presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt == '0));
endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
    import mtc_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                evt_in,
    input  logic                cap_lo_in,
    input  logic                cap_hi_in,
    output logic [2*HALF_W-1:0] count_o,
    output logic [HALF_W-1:0]   cap_lo_o,
    output logic [HALF_W-1:0]   cap_hi_o,
    output logic                irq_lo,
    output logic                irq_hi
);
    localparam int CW = 2 * HALF_W;

    mtc_mode_e         mode_q;
    logic [HALF_W-1:0] div_q [2];
    logic [HALF_W-1:0] mat_lo_q, mat_hi_q;
    logic [HALF_W-1:0] cnt_lo, cnt_hi;
    logic [HALF_W-1:0] nxt_lo, nxt_hi;
    logic [1:0]        ptick;
    logic [2:0]        async_in, rise_v;
    logic              evt_rise, cl_rise, ch_rise;
    logic              en_lo, en_hi, wide;
    logic              set_lo, set_hi;
    logic              mode_wr, clr_wr;

    assign mode_wr = wr_en && (wr_addr == A_MODE);
    assign clr_wr  = wr_en && (wr_addr == A_FLAGCLR);

    // register write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_CAS_EVT;
            div_q[0] <= '0;
            div_q[1] <= '0;
            mat_lo_q <= '1;
            mat_hi_q <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_MODE:   mode_q   <= mtc_mode_e'(wr_data[1:0]);
                A_PRE_LO: div_q[0] <= wr_data;
                A_PRE_HI: div_q[1] <= wr_data;
                A_MAT_LO: mat_lo_q <= wr_data;
                A_MAT_HI: mat_hi_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // one prescaler per half
    for (genvar g = 0; g < 2; g++) begin : g_pre
        mtc_prescaler #(.W(HALF_W)) u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (mode_wr),
            .div  (div_q[g]),
            .tick (ptick[g])
        );
    end

    // synchronizers: event, low trigger, high trigger
    assign async_in = {cap_hi_in, cap_lo_in, evt_in};
    for (genvar s = 0; s < 3; s++) begin : g_sync
        mtc_edge_sync #(.STAGES(2)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (async_in[s]),
            .rise (rise_v[s])
        );
    end
    assign evt_rise = rise_v[0];
    assign cl_rise  = rise_v[1];
    assign ch_rise  = rise_v[2];

    // mode decode: advance sources per half
    always_comb begin
        en_lo = 1'b0;
        en_hi = 1'b0;
        wide  = 1'b0;
        unique case (mode_q)
            MODE_SPLIT_TMR: begin en_lo = ptick[0]; en_hi = ptick[1]; end
            MODE_TMR_EVT:   begin en_lo = ptick[0]; en_hi = evt_rise; end
            MODE_CAS_TMR:   begin en_lo = ptick[0]; wide  = 1'b1;     end
            MODE_CAS_EVT:   begin en_lo = evt_rise; wide  = 1'b1;     end
        endcase
    end

    // next count and wrap detection
    always_comb begin
        nxt_lo = cnt_lo;
        nxt_hi = cnt_hi;
        set_lo = 1'b0;
        set_hi = 1'b0;
        if (wide) begin
            if (en_lo) begin
                if ({cnt_hi, cnt_lo} == {mat_hi_q, mat_lo_q}) begin
                    {nxt_hi, nxt_lo} = '0;
                    set_lo = 1'b1;
                end else begin
                    {nxt_hi, nxt_lo} = {cnt_hi, cnt_lo} + 1'b1;
                end
            end
        end else begin
            if (en_lo) begin
                if (cnt_lo == mat_lo_q) begin nxt_lo = '0; set_lo = 1'b1; end
                else                          nxt_lo = cnt_lo + 1'b1;
            end
            if (en_hi) begin
                if (cnt_hi == mat_hi_q) begin nxt_hi = '0; set_hi = 1'b1; end
                else                          nxt_hi = cnt_hi + 1'b1;
            end
        end
    end

    // counters, flags and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo   <= '0;
            cnt_hi   <= '0;
            irq_lo   <= 1'b0;
            irq_hi   <= 1'b0;
            cap_lo_o <= '0;
            cap_hi_o <= '0;
        end else begin
            if (mode_wr) begin
                cnt_lo <= '0;
                cnt_hi <= '0;
            end else begin
                cnt_lo <= nxt_lo;
                cnt_hi <= nxt_hi;
            end
            irq_lo <= (set_lo && !mode_wr) || (irq_lo && !(clr_wr && wr_data[0]));
            irq_hi <= (set_hi && !mode_wr) || (irq_hi && !(clr_wr && wr_data[1]));
            if (wide) begin
                if (cl_rise) begin
                    cap_lo_o <= cnt_lo;
                    cap_hi_o <= cnt_hi;
                end
            end else begin
                if (cl_rise) cap_lo_o <= cnt_lo;
                if (ch_rise) cap_hi_o <= cnt_hi;
            end
        end
    end

    assign count_o = {cnt_hi, cnt_lo};

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lo) |-> (cnt_lo == '0));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lo && !(clr_wr && wr_data[0])) |=> irq_lo);

    // R10
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (count_o == '0));

    // R5
    event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CAS_EVT && !mode_wr && !evt_rise) |=> $stable(count_o));
endmodule

// File: tb/mtc_timer_test.sv
module mtc_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        evt_in = 1'b0;
    logic        cap_lo_in = 1'b0;
    logic        cap_hi_in = 1'b0;
    logic [15:0] count_o;
    logic [7:0]  cap_lo_o, cap_hi_o;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mtc_timer #(.HALF_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_in(evt_in), .cap_lo_in(cap_lo_in),
        .cap_hi_in(cap_hi_in), .count_o(count_o), .cap_lo_o(cap_lo_o),
        .cap_hi_o(cap_hi_o), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // {mode, pre_lo, pre_hi, mat_lo, mat_hi, cycles, exp_count, exp_irq}
    localparam logic [79:0] VEC [8] = '{
        80'h00_00_01_FF_FF_000A_050A_00,
        80'h00_02_03_02_FF_0014_0500_01,
        80'h02_03_00_FF_FF_0028_000A_00,
        80'h02_00_00_05_01_012C_0026_01,
        80'h01_01_00_FF_FF_0009_0004_00,
        80'h03_00_00_FF_FF_0032_0000_00,
        80'h00_00_00_0F_03_0028_0008_03,
        80'h02_00_00_FF_FF_0104_0104_00
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic evt_pulse();
        @(negedge clk); evt_in = 1'b1;
        repeat (2) @(negedge clk); evt_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic park();
        wr(3'd0, 8'd3);
        wr(3'd5, 8'd3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(count_o == 16'h0 && !irq_lo && !irq_hi, "R1 in reset", count_o, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(count_o == 16'h0 && cap_lo_o == 0 && cap_hi_o == 0 && !irq_lo && !irq_hi,
            "R1 after reset", {cap_hi_o, cap_lo_o, count_o}, 0);

        // vector table
        for (int i = 0; i < 8; i++) begin
            logic [79:0] v;
            string tag;
            v = VEC[i];
            park();
            wr(3'd1, v[71:64]);
            wr(3'd2, v[63:56]);
            wr(3'd3, v[55:48]);
            wr(3'd4, v[47:40]);
            wr(3'd0, v[79:72]);
            repeat (int'(v[39:24])) @(posedge clk);
            @(negedge clk);
            case (v[73:72])
                2'd0: tag = "R2 split timers";
                2'd1: tag = "R3 timer+event";
                2'd2: tag = "R4 cascaded timer";
                default: tag = "R5 cascaded event";
            endcase
            chk(count_o == v[23:8], tag, count_o, v[23:8]);
            chk({irq_hi, irq_lo} == v[1:0], "R6 match flags", {irq_hi, irq_lo}, v[1:0]);
        end

        // R5 event counting in mode 3
        park();
        wr(3'd0, 8'd3);
        repeat (5) evt_pulse();
        repeat (4) @(negedge clk);
        chk(count_o == 16'd5, "R5 five events", count_o, 5);

        // R9 16-bit capture: count = edge index, capture lands 2 edges later
        park();
        wr(3'd1, 8'd0);
        wr(3'd3, 8'hFF);
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'd2);
        repeat (300) @(posedge clk);
        @(negedge clk); cap_lo_in = 1'b1;
        repeat (3) @(negedge clk); cap_lo_in = 1'b0;
        repeat (4) @(negedge clk);
        chk({cap_hi_o, cap_lo_o} == 16'h012E, "R9 16-bit capture",
            {cap_hi_o, cap_lo_o}, 16'h012E);
        @(negedge clk); cap_hi_in = 1'b1;
        repeat (3) @(negedge clk); cap_hi_in = 1'b0;
        repeat (5) @(negedge clk);
        chk({cap_hi_o, cap_lo_o} == 16'h012E, "R9 high trigger ignored",
            {cap_hi_o, cap_lo_o}, 16'h012E);

        // R3/R8 split capture in mode 1
        park();
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'd1);
        repeat (3) evt_pulse();
        repeat (4) @(negedge clk);
        chk(count_o == 16'h0300, "R3 event half", count_o, 16'h0300);
        @(negedge clk); cap_hi_in = 1'b1;
        repeat (3) @(negedge clk); cap_hi_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(cap_hi_o == 8'h03, "R8 high capture", cap_hi_o, 8'h03);
        chk(cap_lo_o == 8'h2E, "R8 low capture untouched", cap_lo_o, 8'h2E);
        @(negedge clk); cap_lo_in = 1'b1;
        repeat (3) @(negedge clk); cap_lo_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(cap_lo_o == 8'h00, "R8 low capture", cap_lo_o, 8'h00);

        // R6/R7 sticky flag and selective clear
        park();
        wr(3'd1, 8'd0);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'd3);
        wr(3'd4, 8'hFF);
        wr(3'd0, 8'd0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        wr(3'd0, 8'd3);
        chk(irq_lo && !irq_hi, "R6 low flag raised", {irq_hi, irq_lo}, 2'b01);
        repeat (5) @(negedge clk);
        chk(irq_lo, "R7 flag sticky", irq_lo, 1);
        wr(3'd5, 8'h02);
        chk(irq_lo, "R7 zero bit keeps flag", irq_lo, 1);
        wr(3'd5, 8'h01);
        chk(!irq_lo, "R7 flag cleared", irq_lo, 0);

        // R10 mode write restarts
        wr(3'd0, 8'd2);
        repeat (50) @(negedge clk);
        wr(3'd0, 8'd2);
        chk(count_o == 16'h0, "R10 cleared on mode write", count_o, 0);
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk(count_o == 16'd7, "R10 restart count", count_o, 7);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule